// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Warning

This block runs from one fast clock that stands in for an oscillator. From it, it derives three banks of four divided clocks and one feedback clock. Each bank and the feedback clock has its own divide ratio. Every divided output keeps a 50% duty cycle, because only even ratios are offered. After the block leaves reset, all dividers start together, so every output rises on the same fast-clock edge.

A sync flag looks ahead to the next cycle in which bank A and bank C rise together. The two banks may run at ratios that are not integer multiples of each other. The flag drops one period of the faster of the two banks before that shared edge and comes back high on the edge itself.

Individual outputs can be parked low through a stop mask, which is shifted in over two wires. Bank C lane 0 and the feedback clock cannot be stopped. A stop or a restart only takes effect while the affected output is low, so no output ever produces a shortened high pulse. One active-low master input resets the whole block and forces every output low.

Top module: `mbank_clkdiv`

## Requirements
- R1: There are three banks of four lanes. While no lane is stopped, all four lanes of a bank show the same waveform.
- R2: A 3-bit ratio code k gives a period of 2(k+1) fast cycles, high for the first k+1 cycles and low for the rest. Counting starts at t=0, the first edge after release.
- R3: The feedback output has its own ratio code with the same encoding as the banks and follows the same timing.
- R4: While `mr_n_i` is low, all outputs and the sync flag are low, and they drop at once, without waiting for a clock edge. After `mr_n_i` rises, every output and the sync flag go high together on the third rising clock edge. That edge is t=0.
- R5: Let L be the least common multiple of the bank A and bank C periods, F the smaller of the two periods, and m = t mod L. The sync flag is low when m ≥ L−F and m ≠ 0, and high otherwise.
- R6: The sync flag only rises in the cycle in which bank A and bank C rise together.
- R7: While `ser_en_i` is high, each clock shifts `ser_dat_i` into bit 0 of a 12-bit register, and earlier bits move toward bit 11. On the first clock with `ser_en_i` low after it was high, the register becomes the stop mask. The mask is cleared by reset.
- R8: Mask bit 1 stops a lane. Bits 0–3 map to bank A lanes 0–3, bits 4–7 to bank B, and bits 8–11 to bank C. A stopped lane stays low.
- R9: Mask bit 8 has no effect: bank C lane 0 always runs, and the feedback output cannot be stopped.
- R10: A change to a lane's stop state takes effect only on a clock edge at which that lane's divider is low. Every high pulse therefore lasts exactly k+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| mr_n_i | input | 1 | Active-low master reset and output disable |
| div_a_i | input | 3 | Bank A ratio code k, period 2(k+1) |
| div_b_i | input | 3 | Bank B ratio code |
| div_c_i | input | 3 | Bank C ratio code |
| div_fb_i | input | 3 | Feedback ratio code |
| ser_dat_i | input | 1 | Serial stop-mask data |
| ser_en_i | input | 1 | Serial shift enable; its falling edge loads the mask |
| clk_a_o | output | 4 | Bank A clocks |
| clk_b_o | output | 4 | Bank B clocks |
| clk_c_o | output | 4 | Bank C clocks |
| clk_fb_o | output | 1 | Feedback clock |
| sync_o | output | 1 | Coincidence warning flag |

## Verification
A stop-mask update can land on the same edge at which a lane's divider rises. In that cycle the gating rule decides whether the lane gets a full pulse or none at all. The bench provokes this by alternately loading all-stop and all-run masks, moving the end of each load by one cycle at a time across a whole bank period, so every phase is hit. A monitor measures every high pulse on every output, and any width other than k+1 counts as a failure. The steady state after the sweep is then compared with the cycle model.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;
  localparam int CODE_W = 3;
  localparam int LANES  = 4;
  localparam int MASK_W = 3 * LANES;
  localparam int PER_W  = 8;
  localparam int HMAX   = 1 << CODE_W;

  // least common multiple of two even periods, from their half periods
  function automatic logic [PER_W-1:0] lcm_period(input logic [CODE_W-1:0] ka,
                                                  input logic [CODE_W-1:0] kc);
    int ha, hc, res;
    ha  = int'(ka) + 1;
    hc  = int'(kc) + 1;
    res = ha * hc;
    for (int m = HMAX; m >= 1; m--) begin
      if (((ha * m) % hc) == 0) res = ha * m;
    end
    return PER_W'(2 * res);
  endfunction

  function automatic logic [PER_W-1:0] fast_period(input logic [CODE_W-1:0] ka,
                                                   input logic [CODE_W-1:0] kc);
    int ha, hc;
    ha = int'(ka) + 1;
    hc = int'(kc) + 1;
    return PER_W'(2 * ((ha < hc) ? ha : hc));
  endfunction
endpackage

// File: rtl/mbcd_rst_sync.sv
module mbcd_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_no = ff2_q;
endmodule

// File: rtl/mbcd_divider.sv
module mbcd_divider
  import mbcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] half_m1_i,
  output logic              q_o,
  output logic              q_nx_o
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              q_q, q_d;

  always_comb begin
    cnt_d = cnt_q - ONE;
    q_d   = q_q;
    if (cnt_q == '0) begin
      cnt_d = half_m1_i;
      q_d   = ~q_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q_o    = q_q;
  assign q_nx_o = q_d;
endmodule

// File: rtl/mbcd_gate.sv
module mbcd_gate #(
  parameter int              N       = 4,
  parameter logic [N-1:0]    STOP_EN = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         q_i,
  input  logic         q_nx_i,
  input  logic [N-1:0] stop_i,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] en_q, en_d, out_q, out_d, stop_eff;

  assign stop_eff = stop_i & STOP_EN;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      en_d[i]  = q_i ? en_q[i] : ~stop_eff[i];
      out_d[i] = q_nx_i & en_d[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '1;
      out_q <= '0;
    end else begin
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/mbcd_sync.sv
module mbcd_sync
  import mbcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_c_i,
  output logic              sync_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] per_l, per_f, d_q, d_d;
  logic             s_q, s_d;

  assign per_l = lcm_period(code_a_i, code_c_i);
  assign per_f = fast_period(code_a_i, code_c_i);

  always_comb begin
    d_d = (d_q == '0) ? (per_l - ONE) : (d_q - ONE);
    s_d = (d_d == (per_l - ONE)) || (d_d >= per_f);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      s_q <= 1'b0;
    end else begin
      d_q <= d_d;
      s_q <= s_d;
    end
  end

  assign sync_o = s_q;
endmodule

// File: rtl/mbcd_stop_shift.sv
module mbcd_stop_shift
  import mbcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dat_i,
  input  logic              en_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] sh_q, sh_d, mask_q, mask_d;
  logic              en_q;

  always_comb begin
    sh_d   = en_i ? {sh_q[MASK_W-2:0], dat_i} : sh_q;
    mask_d = (en_q && !en_i) ? sh_q : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      mask_q <= mask_d;
      en_q   <= en_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
  import mbcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              mr_n_i,
  input  logic [CODE_W-1:0] div_a_i,
  input  logic [CODE_W-1:0] div_b_i,
  input  logic [CODE_W-1:0] div_c_i,
  input  logic [CODE_W-1:0] div_fb_i,
  input  logic              ser_dat_i,
  input  logic              ser_en_i,
  output logic [LANES-1:0]  clk_a_o,
  output logic [LANES-1:0]  clk_b_o,
  output logic [LANES-1:0]  clk_c_o,
  output logic              clk_fb_o,
  output logic              sync_o
);
  localparam int NDIV = 4;

  logic                 rst_n_s;
  logic [MASK_W-1:0]    stop_mask;
  logic [CODE_W-1:0]    code [NDIV];
  logic [NDIV-1:0]      q_cur, q_nxt;
  logic [LANES-1:0]     lanes [3];
  logic [0:0]           fb_w;
  logic                 q_a, q_c;

  assign code[0] = div_a_i;
  assign code[1] = div_b_i;
  assign code[2] = div_c_i;
  assign code[3] = div_fb_i;

  mbcd_rst_sync u_rst (.clk_i(clk_i), .arst_ni(mr_n_i), .rst_no(rst_n_s));

  mbcd_stop_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_n_s), .dat_i(ser_dat_i), .en_i(ser_en_i),
    .mask_o(stop_mask)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    mbcd_divider u_div (
      .clk_i(clk_i), .rst_ni(rst_n_s), .half_m1_i(code[g]),
      .q_o(q_cur[g]), .q_nx_o(q_nxt[g])
    );
  end

  // bank C lane 0 is never stoppable
  for (genvar b = 0; b < 3; b++) begin : g_bank
    localparam logic [LANES-1:0] SEN = (b == 2) ? {{(LANES-1){1'b1}}, 1'b0} : '1;
    mbcd_gate #(.N(LANES), .STOP_EN(SEN)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_n_s), .q_i(q_cur[b]), .q_nx_i(q_nxt[b]),
      .stop_i(stop_mask[b*LANES +: LANES]), .clk_o(lanes[b])
    );
  end

  mbcd_gate #(.N(1), .STOP_EN(1'b0)) u_gate_fb (
    .clk_i(clk_i), .rst_ni(rst_n_s), .q_i(q_cur[3]), .q_nx_i(q_nxt[3]),
    .stop_i(1'b0), .clk_o(fb_w)
  );

  mbcd_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s), .code_a_i(div_a_i), .code_c_i(div_c_i),
    .sync_o(sync_o)
  );

  assign q_a      = q_cur[0];
  assign q_c      = q_cur[2];
  assign clk_a_o  = lanes[0];
  assign clk_b_o  = lanes[1];
  assign clk_c_o  = lanes[2];
  assign clk_fb_o = fb_w[0];
endmodule

// File: rtl/mbank_clkdiv_chk.sv
module mbank_clkdiv_chk (
  input logic       clk_i,
  input logic       mr_n_i,
  input logic       rst_n_s,
  input logic [3:0] clk_a_o,
  input logic [3:0] clk_b_o,
  input logic [3:0] clk_c_o,
  input logic       clk_fb_o,
  input logic       sync_o,
  input logic       qa,
  input logic       qc,
  input logic [3:0] ena,
  input logic [2:0] div_a_i
);
  logic [4:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) hi_cnt <= '0;
    else          hi_cnt <= clk_a_o[0] ? hi_cnt + 5'd1 : 5'd0;
  end

  // R4: outputs quiet while master control is low
  always @(posedge clk_i) begin
    if (!mr_n_i) begin
      p_reset_quiet_r4: assert ({clk_a_o, clk_b_o, clk_c_o, clk_fb_o, sync_o} == '0)
        else $error("outputs active during master reset");
    end
  end

  p_sync_rise_coincident_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(sync_o) |-> ($rose(qa) && $rose(clk_c_o[0])));

  p_sync_low_before_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($rose(qa) && $rose(clk_c_o[0])) |-> !$past(sync_o));

  p_c0_never_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    clk_c_o[0] == qc);

  p_enable_change_low_r10: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !$stable(ena) |-> !$past(qa));

  p_pulse_width_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(clk_a_o[0]) |-> (hi_cnt == ({2'b00, div_a_i} + 5'd1)));
endmodule

bind mbank_clkdiv mbank_clkdiv_chk u_chk (
  .clk_i(clk_i), .mr_n_i(mr_n_i), .rst_n_s(rst_n_s),
  .clk_a_o(clk_a_o), .clk_b_o(clk_b_o), .clk_c_o(clk_c_o), .clk_fb_o(clk_fb_o),
  .sync_o(sync_o), .qa(q_a), .qc(q_c), .ena(g_bank[0].u_gate.en_q), .div_a_i(div_a_i)
);

// File: tb/mbank_clkdiv_bench.sv
`timescale 1ns/1ps
module mbank_clkdiv_bench;
  logic       clk = 1'b0;
  logic       mr_n = 1'b0;
  logic [2:0] div_a = 3'd0, div_b = 3'd0, div_c = 3'd0, div_fb = 3'd0;
  logic       ser_dat = 1'b0, ser_en = 1'b0;
  logic [3:0] clk_a, clk_b, clk_c;
  logic       clk_fb, sync;

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  int hi_run [14];

  always #2 clk = ~clk;

  mbank_clkdiv u_mbank_clkdiv (
    .clk_i(clk), .mr_n_i(mr_n), .div_a_i(div_a), .div_b_i(div_b), .div_c_i(div_c),
    .div_fb_i(div_fb), .ser_dat_i(ser_dat), .ser_en_i(ser_en),
    .clk_a_o(clk_a), .clk_b_o(clk_b), .clk_c_o(clk_c), .clk_fb_o(clk_fb), .sync_o(sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
    end
  endtask

  function automatic bit wave(input int code, input int tt);
    int p;
    p = 2 * (code + 1);
    return (tt % p) < (code + 1);
  endfunction

  function automatic int lcm_b(input int a, input int b);
    for (int x = a; x <= a * b; x += a) if (x % b == 0) return x;
    return a * b;
  endfunction

  task automatic tick();
    @(posedge clk);
    t++;
    @(negedge clk);
  endtask

  // pulse-width monitor on every output (R10)
  always @(posedge clk) begin
    #1;
    if (!mr_n) begin
      for (int i = 0; i < 14; i++) hi_run[i] = 0;
    end else begin
      for (int i = 0; i < 14; i++) begin
        bit v;
        int code;
        v    = (i < 4) ? clk_a[i] : (i < 8) ? clk_b[i-4] : (i < 12) ? clk_c[i-8] : (i == 12) ? clk_fb : 1'b0;
        code = (i < 4) ? int'(div_a) : (i < 8) ? int'(div_b) : (i < 12) ? int'(div_c) : int'(div_fb);
        if (i == 13) continue;
        if (v) hi_run[i]++;
        else if (hi_run[i] != 0) begin
          chk(hi_run[i] == code + 1, "R10 pulse width", hi_run[i], code + 1);
          hi_run[i] = 0;
        end
      end
    end
  end

  task automatic reset_and_release(input logic [2:0] ka, kb, kc, kf);
    mr_n = 1'b0; ser_en = 1'b0;
    div_a = ka; div_b = kb; div_c = kc; div_fb = kf;
    repeat (3) @(negedge clk);
    chk({clk_a, clk_b, clk_c, clk_fb, sync} == 0, "R4 quiet in reset",
        int'({clk_a, clk_b, clk_c, clk_fb, sync}), 0);
    mr_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk({clk_a, clk_b, clk_c, clk_fb, sync} == 0, "R4 still low before third edge",
        int'({clk_a, clk_b, clk_c, clk_fb, sync}), 0);
    @(posedge clk);
    t = 0;
    @(negedge clk);
    chk({clk_a, clk_b, clk_c, clk_fb, sync} == 14'h3FFF, "R4 aligned start",
        int'({clk_a, clk_b, clk_c, clk_fb, sync}), 14'h3FFF);
  endtask

  task automatic check_cycles(input int n, input logic [11:0] m);
    int pl, pf, mm;
    bit es;
    pl = lcm_b(2 * (int'(div_a) + 1), 2 * (int'(div_c) + 1));
    pf = 2 * ((div_a < div_c) ? (int'(div_a) + 1) : (int'(div_c) + 1));
    for (int k = 0; k < n; k++) begin
      logic [3:0] ea, eb, ec;
      ea = {4{wave(div_a, t)}} & ~m[3:0];
      eb = {4{wave(div_b, t)}} & ~m[7:4];
      ec = {4{wave(div_c, t)}} & ~{m[11:9], 1'b0};
      chk(clk_a == ea, "R2/R8 bank A", clk_a, ea);
      chk(clk_b == eb, "R1/R8 bank B", clk_b, eb);
      chk(clk_c == ec, "R9/R8 bank C", clk_c, ec);
      chk(clk_fb == wave(div_fb, t), "R3 feedback", clk_fb, wave(div_fb, t));
      mm = t % pl;
      es = (mm == 0) || (mm < pl - pf);
      chk(sync == es, "R5/R6 sync", sync, es);
      tick();
    end
  endtask

  task automatic load_mask(input logic [11:0] m);
    for (int i = 11; i >= 0; i--) begin
      ser_en = 1'b1; ser_dat = m[i];
      tick();
    end
    ser_en = 1'b0; ser_dat = 1'b0;
    tick();
  endtask

  task automatic test_ratios(input logic [2:0] ka, kb, kc, kf, input int n);
    reset_and_release(ka, kb, kc, kf);
    check_cycles(n, 12'h000);
  endtask

  task automatic test_stop();
    reset_and_release(3'd2, 3'd1, 3'd3, 3'd4);
    load_mask(12'hFFF);
    repeat (40) tick();
    check_cycles(64, 12'hFFF);           // R8, R9
    load_mask(12'h5A3);                  // R7 shift order, bit 8 ignored
    repeat (40) tick();
    check_cycles(64, 12'h5A3);
    load_mask(12'h000);
    repeat (40) tick();
    check_cycles(64, 12'h000);
  endtask

  task automatic test_glitch_sweep();
    reset_and_release(3'd3, 3'd2, 3'd1, 3'd6);
    for (int off = 0; off < 16; off++) begin
      repeat (off) tick();
      load_mask((off % 2 == 0) ? 12'hFFF : 12'h000);  // R10 change at every phase
    end
    repeat (40) tick();
    check_cycles(32, 12'h000);
  endtask

  task automatic test_async_reset();
    reset_and_release(3'd1, 3'd2, 3'd3, 3'd0);
    repeat (7) tick();
    mr_n = 1'b0;
    #1;
    chk({clk_a, clk_b, clk_c, clk_fb, sync} == 0, "R4 immediate disable",
        int'({clk_a, clk_b, clk_c, clk_fb, sync}), 0);
    @(negedge clk);
  endtask

  task automatic test_mask_cleared();
    reset_and_release(3'd2, 3'd2, 3'd2, 3'd2);
    load_mask(12'hFFF);
    repeat (20) tick();
    reset_and_release(3'd2, 3'd2, 3'd2, 3'd2);
    check_cycles(24, 12'h000);           // R7 mask cleared by reset
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_ratios(3'd2, 3'd3, 3'd1, 3'd5, 200);   // A/C = 1.5
    test_ratios(3'd4, 3'd0, 3'd7, 3'd7, 240);   // 10 vs 16
    test_ratios(3'd3, 3'd6, 3'd3, 3'd0, 64);    // equal ratios
    test_ratios(3'd0, 3'd2, 3'd7, 3'd1, 64);    // 2 vs 16
    test_ratios(3'd6, 3'd7, 3'd5, 3'd3, 200);   // 14 vs 12
    test_stop();
    test_glitch_sweep();
    test_async_reset();
    test_mask_cleared();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule